// File: doc/BRIEF.md
# SCL Stall Timeout Timer

This block watches the serial clock line of a two-wire bus master and measures how long that line stays low while a transfer is active. A target that stretches the clock for too long holds the line low. When this happens the timer raises a sticky timeout flag. The master status logic treats the flag as an error that ends the transfer.

The timer counts in ticks. A tick comes every 2^N system clocks, where N is a log2 divider exponent from 0 to 14. The terminal count is a 15-bit limit value. Between them, these two settings cover wait windows from a few clocks up to hundreds of millions of clocks. Software sets the exponent to the smallest value that lets the wanted wait, typically around 25 ms, fit in the 15-bit limit.

The count restarts whenever SCL is seen high, when the transfer qualifier is low, or when the timer is disabled. The divider counter runs freely while the timer is enabled and returns to zero when it is disabled.

Top module: `scl_stall_timer`

## Requirements
- R1: After reset, `timeout_flag` is 0, the timer is disabled, the limit is 0 and the exponent is 0.
- R2: A write on `ctl_wr` loads the enable from `ctl_wdata[15]` and the limit from `ctl_wdata[14:0]`. If the block was disabled before the write, and SCL is held low with `xfer_active` high, then `timeout_flag` rises exactly limit × 2^N clocks after the enabling write edge.
- R3: A write on `div_wr` loads the exponent N from `div_wdata[3:0]`. Values above 14 are stored as 14.
- R4: Any cycle with `scl_in` high resets the tick count to zero. Expiry then needs a full limit of ticks with SCL low again.
- R5: While disabled, or while `xfer_active` is low, the count stays at zero and the flag cannot rise. Disabling also resets the divider counter to zero.
- R6: Once set, `timeout_flag` holds its value until it is cleared, even after SCL returns high.
- R7: A write on `clr_wr` with `clr_wdata` = 1 clears the flag. The same write with `clr_wdata` = 0 has no effect.
- R8: A pulse on `xfer_start` clears the flag.
- R9: If an expiry and a clear land in the same cycle, the flag ends up set.
- R10: A new exponent takes effect only at the next restart of the count. Changing it mid-count leaves the running window unchanged.
- R11: Each low-SCL window raises the flag at most once: after expiry the count holds until a restart. A limit of 0 never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Bit 15 is the enable; bits 14:0 are the limit in ticks |
| div_wr | input | 1 | Exponent write strobe |
| div_wdata | input | 4 | log2 of the system clocks per tick |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_wdata | input | 1 | 1 clears the flag; 0 has no effect |
| xfer_start | input | 1 | Start-of-transfer pulse; clears the flag |
| xfer_active | input | 1 | High while a transfer is in progress |
| scl_in | input | 1 | Sampled SCL level |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
An expiry and a software clear can fall on the same clock edge. The bench provokes this by releasing SCL low at a known cycle with an exponent of 0. It then times a write-1 clear so that the clear is sampled on the exact edge at which the limit is reached. The scoreboard must see the flag rise on that edge, and the flag must still read 1 one cycle later. A separate clear issued afterwards must bring the flag to 0.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int DEF_LIMIT_W = 15;
  localparam int DEF_EXP_W   = 4;
  localparam int DEF_MAX_EXP = 14;
endpackage

// File: rtl/stt_regs.sv
module stt_regs #(
  parameter int LIMIT_W = 15,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [LIMIT_W:0]   ctl_wdata,
  input  logic               div_wr,
  input  logic [EXP_W-1:0]   div_wdata,
  input  logic               restart,
  output logic               en,
  output logic [LIMIT_W-1:0] limit,
  output logic [EXP_W-1:0]   exp_act
);
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);

  logic               en_q, en_d;
  logic [LIMIT_W-1:0] lim_q, lim_d;
  logic [EXP_W-1:0]   exp_q, exp_d;
  logic [EXP_W-1:0]   act_q, act_d;

  always_comb begin
    en_d  = en_q;
    lim_d = lim_q;
    if (ctl_wr) begin
      en_d  = ctl_wdata[LIMIT_W];
      lim_d = ctl_wdata[LIMIT_W-1:0];
    end
    exp_d = exp_q;
    if (div_wr) exp_d = (div_wdata > EXP_CAP) ? EXP_CAP : div_wdata;
    act_d = restart ? exp_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lim_q <= '0;
      exp_q <= '0;
      act_q <= '0;
    end else begin
      en_q  <= en_d;
      lim_q <= lim_d;
      exp_q <= exp_d;
      act_q <= act_d;
    end
  end

  assign en      = en_q;
  assign limit   = lim_q;
  assign exp_act = act_q;
endmodule

// File: rtl/stt_prescaler.sv
module stt_prescaler #(
  parameter int PRE_W = 14,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [EXP_W-1:0] exp_act,
  output logic             tick
);
  generate
    if (PRE_W == 0) begin : g_nodiv
      assign tick = en;
    end else begin : g_div
      logic [PRE_W-1:0] pcnt_q, pcnt_d;
      logic [PRE_W-1:0] mask;

      always_comb begin
        mask   = ~({PRE_W{1'b1}} << exp_act);
        pcnt_d = en ? pcnt_q + PRE_W'(1) : '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
      end

      assign tick = en && ((pcnt_q & mask) == mask);
    end
  endgenerate
endmodule

// File: rtl/stt_counter.sv
module stt_counter #(
  parameter int LIMIT_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               tick,
  input  logic [LIMIT_W-1:0] limit,
  output logic               fire
);
  logic [LIMIT_W-1:0] cnt_q, cnt_d;
  logic [LIMIT_W:0]   inc;
  logic               done;

  always_comb begin
    inc  = {1'b0, cnt_q} + (LIMIT_W+1)'(1);
    done = (cnt_q >= limit);
    fire = tick && !restart && !done && (inc == {1'b0, limit});
    if (restart)            cnt_d = '0;
    else if (tick && !done) cnt_d = inc[LIMIT_W-1:0];
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stt_flag.sv
module stt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr_hit,
  input  logic xfer_start,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = fire | (flag_q & ~clr_hit & ~xfer_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/scl_stall_timer.sv
module scl_stall_timer
  import stt_pkg::*;
#(
  parameter int LIMIT_W = DEF_LIMIT_W,
  parameter int EXP_W   = DEF_EXP_W,
  parameter int MAX_EXP = DEF_MAX_EXP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [LIMIT_W:0]   ctl_wdata,
  input  logic               div_wr,
  input  logic [EXP_W-1:0]   div_wdata,
  input  logic               clr_wr,
  input  logic               clr_wdata,
  input  logic               xfer_start,
  input  logic               xfer_active,
  input  logic               scl_in,
  output logic               timeout_flag
);
  logic               en;
  logic [LIMIT_W-1:0] limit;
  logic [EXP_W-1:0]   exp_act;
  logic               restart;
  logic               tick;
  logic               fire;

  assign restart = !en || scl_in || !xfer_active;

  stt_regs #(.LIMIT_W(LIMIT_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .restart(restart),
    .en(en), .limit(limit), .exp_act(exp_act)
  );

  stt_prescaler #(.PRE_W(MAX_EXP), .EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .exp_act(exp_act), .tick(tick)
  );

  stt_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .limit(limit), .fire(fire)
  );

  stt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .fire(fire), .clr_hit(clr_wr & clr_wdata),
    .xfer_start(xfer_start), .flag(timeout_flag)
  );
endmodule

// File: rtl/stt_checker.sv
module stt_checker #(
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_in,
  input logic             xfer_active,
  input logic             xfer_start,
  input logic             clr_wr,
  input logic             clr_wdata,
  input logic             en,
  input logic             restart,
  input logic             fire,
  input logic [EXP_W-1:0] exp_act,
  input logic             timeout_flag
);
  AST_EXP_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    exp_act <= EXP_W'(MAX_EXP)); // R3

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(!scl_in)); // R4

  AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !xfer_active) |=> !$rose(timeout_flag)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag && !(clr_wr && clr_wdata) && !xfer_start |=> timeout_flag); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_wdata && !fire |=> !timeout_flag); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && !fire |=> !timeout_flag); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> timeout_flag); // R9

  AST_EXP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(exp_act)); // R10
endmodule

bind scl_stall_timer stt_checker #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .xfer_active(xfer_active),
  .xfer_start(xfer_start), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
  .en(en), .restart(restart), .fire(fire), .exp_act(exp_act),
  .timeout_flag(timeout_flag)
);

// File: tb/scl_stall_timer_test.sv
module scl_stall_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        div_wr = 1'b0;
  logic [3:0]  div_wdata = '0;
  logic        clr_wr = 1'b0;
  logic        clr_wdata = 1'b0;
  logic        xfer_start = 1'b0;
  logic        xfer_active = 1'b1;
  logic        scl_in = 1'b0;
  logic        timeout_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit prev_flag = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_stall_timer uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .clr_wr(clr_wr),
    .clr_wdata(clr_wdata), .xfer_start(xfer_start),
    .xfer_active(xfer_active), .scl_in(scl_in), .timeout_flag(timeout_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic push_rise(input int at, input string req);
    exp_q.push_back(at);
    tag_q.push_back(req);
  endtask

  // monitor: pops the expected rise cycle when the flag rises
  always @(negedge clk) begin
    if (rst_n) begin
      if (timeout_flag && !prev_flag) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected rise", cyc, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cyc == e, t, cyc, e);
        end
      end
      prev_flag = timeout_flag;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input bit e, input int lim, output int m);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = {e, 15'(lim)};
    @(posedge clk); #1;
    ctl_wr = 1'b0;
    m = cyc;
  endtask

  task automatic wr_div(input int v);
    @(negedge clk);
    div_wr = 1'b1;
    div_wdata = 4'(v);
    @(posedge clk); #1;
    div_wr = 1'b0;
  endtask

  task automatic wr_clr(input bit b);
    @(negedge clk);
    clr_wr = 1'b1;
    clr_wdata = b;
    @(posedge clk); #1;
    clr_wr = 1'b0;
  endtask

  task automatic set_scl(input bit v, output int m);
    @(negedge clk);
    scl_in = v;
    m = cyc;
  endtask

  task automatic chk_flag(input bit expv, input string req);
    @(negedge clk);
    check(timeout_flag == expv, req, int'(timeout_flag), int'(expv));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int m, m2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_flag(1'b0, "R1 reset flag");

    // R2: enable, exponent 0, limit 5
    wr_ctl(1'b1, 5, m);
    push_rise(m + 5, "R2 expiry cycle N=0");
    wait_n(8);
    check(timeout_flag == 1'b1, "R2 flag set", int'(timeout_flag), 1);

    // R7: write of 0 ignored, write of 1 clears
    wr_clr(1'b0);
    chk_flag(1'b1, "R7 clear with 0 ignored");
    wr_clr(1'b1);
    chk_flag(1'b0, "R7 clear with 1");
    wait_n(10);
    check(timeout_flag == 1'b0, "R11 single event per window", int'(timeout_flag), 0);

    // R4: restart mid-count
    set_scl(1'b1, m);
    set_scl(1'b0, m);
    wait_n(2);
    set_scl(1'b1, m2);
    set_scl(1'b0, m2);
    push_rise(m2 + 5, "R4 restart on SCL high");
    wait_n(8);
    check(timeout_flag == 1'b1, "R4 flag after restart", int'(timeout_flag), 1);

    // R6: sticky with SCL high
    set_scl(1'b1, m);
    wait_n(4);
    check(timeout_flag == 1'b1, "R6 sticky", int'(timeout_flag), 1);

    // R8: transfer start clears
    @(negedge clk);
    xfer_start = 1'b1;
    @(posedge clk); #1;
    xfer_start = 1'b0;
    chk_flag(1'b0, "R8 start clears");

    // R9: expiry and clear on the same edge
    set_scl(1'b0, m);
    push_rise(m + 5, "R9 set on collision edge");
    wait_n(3);
    wr_clr(1'b1);
    chk_flag(1'b1, "R9 set wins over clear");
    wr_clr(1'b1);
    chk_flag(1'b0, "R9 later clear");

    // R5: transfer qualifier low blocks counting
    set_scl(1'b1, m);
    xfer_active = 1'b0;
    set_scl(1'b0, m);
    wait_n(20);
    check(timeout_flag == 1'b0, "R5 inactive no count", int'(timeout_flag), 0);
    @(negedge clk);
    xfer_active = 1'b1;
    m = cyc;
    push_rise(m + 5, "R5 count after qualifier");
    wait_n(8);
    check(timeout_flag == 1'b1, "R5 flag after qualifier", int'(timeout_flag), 1);
    wr_clr(1'b1);

    // R5: disabled block never raises
    wr_ctl(1'b0, 5, m);
    set_scl(1'b1, m);
    set_scl(1'b0, m);
    wait_n(20);
    check(timeout_flag == 1'b0, "R5 disabled no count", int'(timeout_flag), 0);

    // R2: exponent 2, limit 3
    wr_div(2);
    wr_ctl(1'b1, 3, m);
    push_rise(m + 12, "R2 expiry cycle N=2");
    wait_n(16);
    check(timeout_flag == 1'b1, "R2 flag N=2", int'(timeout_flag), 1);

    // R10: exponent change mid-count is deferred
    wr_ctl(1'b0, 8, m);
    wr_clr(1'b1);
    wr_div(1);
    wr_ctl(1'b1, 8, m);
    push_rise(m + 16, "R10 old exponent kept");
    wait_n(4);
    wr_div(3);
    wait_n(16);
    check(timeout_flag == 1'b1, "R10 flag with old exponent", int'(timeout_flag), 1);
    wr_ctl(1'b0, 8, m);
    wr_clr(1'b1);
    wr_ctl(1'b1, 8, m);
    push_rise(m + 64, "R10 new exponent after restart");
    wait_n(70);
    check(timeout_flag == 1'b1, "R10 flag with new exponent", int'(timeout_flag), 1);

    // R3: exponent 15 clamps to 14
    wr_ctl(1'b0, 1, m);
    wr_clr(1'b1);
    wr_div(15);
    wr_ctl(1'b1, 1, m);
    push_rise(m + 16384, "R3 clamped exponent");
    wait_n(16384 - 10);
    check(timeout_flag == 1'b0, "R3 not early", int'(timeout_flag), 0);
    wait_n(20);
    check(timeout_flag == 1'b1, "R3 flag with exponent 14", int'(timeout_flag), 1);

    // R11: limit zero never raises
    wr_ctl(1'b0, 0, m);
    wr_clr(1'b1);
    wr_div(0);
    wr_ctl(1'b1, 0, m);
    wait_n(30);
    check(timeout_flag == 1'b0, "R11 limit zero", int'(timeout_flag), 0);

    while (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(1'b0, t, -1, e);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule